// File: doc/BRIEF.md
# Multi-channel SAR ADC sequencer

This block is the digital half of a 12-bit successive-approximation converter with up to eight analog inputs. Software reaches it through a small word-addressed register bus. It picks one input through the analog mux, waits out a programmable sampling window and then runs a binary search. Each trial code goes to the DAC, and the search keeps or drops each bit according to an external comparator. The finished code goes into that channel's result register, and a completion flag and an optional interrupt follow.

A conversion starts from software by setting the enable bit while exactly one channel is selected. In single mode the block converts once and drops enable by itself. In repeat mode it keeps converting the same channel until software clears enable. It then finishes the conversion in progress before it goes idle. A bad channel selection starts nothing and raises a selection-error flag instead. The power and soft-reset bits gate all activity.

Top module: `sar_seq`

## Requirements
- R1: After reset the timing word (0x0C) reads 0x000E0578, the sampling period being bits 15:0, bits 23:16 reading the fixed compare value 0x0E and bits 31:24 reading 0. Writes change only the period. The divider word (0x28) always reads 4, whatever is written.
- R2: Writing control (0x00) with bit 0 (enable), bit 2 (power) and bit 15 (reset release) all set, while the channel mask (0x08, bits 7:0) has exactly one bit set, starts a conversion. Control bit 1 (busy) reads 1 from the next cycle on, and the mux select equals the index of the set mask bit.
- R3: A conversion with sampling period P ends 4*max(P,1)+48 clocks after the starting write edge. The result word at 0x30+4*n then holds, in bits 11:0, the 12-bit code that the MSB-first search against the comparator finds.
- R4: At the end of a conversion, status (0x24) bit n is set for the converted channel n.
- R5: In single mode (mode word 0x04 bit 1 = 0), enable and busy both read 0 after the conversion ends.
- R6: In repeat mode (mode bit 1 = 1), the same channel converts again at once, and each further result is due 4*max(P,1)+48 clocks after the previous one.
- R7: Clearing enable during a conversion makes enable read 0 at once. Busy stays 1 until the conversion in progress completes and stores its result, and then it reads 0.
- R8: An enable write while the mask is zero or has several bits set starts nothing. It sets status bit 16 and leaves enable and busy at 0.
- R9: Writing status clears each flag written as 1 and leaves the others unchanged.
- R10: In the interrupt word (0x20), bits 7:0 enable the per-channel completion interrupts and bit 16 enables the selection-error interrupt. With bit 31 at 0 the interrupt output gives a one-cycle pulse for each enabled event. With bit 31 at 1 it stays high while any enabled flag is set.
- R11: While power (bit 2) or reset release (bit 15) is written as 0, an enable write starts nothing and sets no flag, and busy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWe | input | 1 | Write strobe, one word per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above the DAC code |
| dacCode | output | 12 | Trial code to the DAC |
| muxSel | output | 3 | Analog input selected |
| irq | output | 1 | Interrupt output, pulse or level |

## Verification
A write takes effect at the clock edge that samples it. Busy and enable therefore read back on the following cycle, and a conversion ends exactly 4*max(P,1)+48 edges after the starting write. A behavioural model in the bench counts those edges and, on every falling edge, compares the idle-bus control readback, the interrupt output and the mux select with its prediction. The result, status and register readbacks are sampled only once the model says the conversion has finished. Comparator input changes are made only during a sampling window, where they cannot disturb a search.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h00;
  localparam logic [7:0] ADDR_MODE   = 8'h04;
  localparam logic [7:0] ADDR_CHSEL  = 8'h08;
  localparam logic [7:0] ADDR_TIMING = 8'h0C;
  localparam logic [7:0] ADDR_INTEN  = 8'h20;
  localparam logic [7:0] ADDR_STATUS = 8'h24;
  localparam logic [7:0] ADDR_DIV    = 8'h28;
  localparam logic [7:0] ADDR_RES0   = 8'h30;
  localparam logic [7:0] CMP_FIXED   = 8'h0E;
  localparam logic [31:0] MODE_MASK  = 32'h0000_3017;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONVERT} seqState_t;

  typedef struct packed {
    logic sarInit;
    logic sarStep;
    logic convDone;
    logic selErr;
  } seqStrobe_t;
endpackage

// File: rtl/sar_control.sv
module sar_control
  import sar_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int PER_W  = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int STEP_W = $clog2(RES_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              wrEn,
  input  logic              wrPwr,
  input  logic              wrRel,
  input  logic              active,
  input  logic [NUM_CH-1:0] chMask,
  input  logic              repeatMode,
  input  logic [PER_W-1:0]  period,
  output seqStrobe_t        strobe,
  output logic              enable,
  output logic              busy,
  output logic [CH_W-1:0]   chIdx
);
  seqState_t         state;
  logic [1:0]        divCnt;
  logic [PER_W-1:0]  sampCnt;
  logic [STEP_W-1:0] stepCnt;
  logic              actNext, tick, maskOk, lastSample, lastStep, enNext;
  logic [CH_W-1:0]   maskIdx;

  assign actNext    = ctrlWr ? (wrPwr & wrRel) : active;
  assign tick       = (state != ST_IDLE) && (divCnt == 2'd3);
  assign maskOk     = (chMask != '0) && ((chMask & (chMask - 1'b1)) == '0);
  assign lastSample = ({1'b0, sampCnt} + 1'b1) >= {1'b0, period};
  assign lastStep   = (stepCnt == STEP_W'(RES_W - 1));
  assign enNext     = ctrlWr ? wrEn : enable;
  assign busy       = (state != ST_IDLE);

  always_comb begin
    maskIdx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (chMask[i]) maskIdx = CH_W'(i);
  end

  always_comb begin
    strobe.selErr   = actNext && (state == ST_IDLE) && ctrlWr && wrEn && !maskOk;
    strobe.sarInit  = actNext && (state == ST_SAMPLE) && tick && lastSample;
    strobe.sarStep  = actNext && (state == ST_CONVERT) && tick;
    strobe.convDone = strobe.sarStep && lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      enable  <= 1'b0;
      divCnt  <= '0;
      sampCnt <= '0;
      stepCnt <= '0;
      chIdx   <= '0;
    end else if (!actNext) begin
      state  <= ST_IDLE;
      enable <= 1'b0;
      divCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ctrlWr && wrEn && maskOk) begin
            state   <= ST_SAMPLE;
            enable  <= 1'b1;
            divCnt  <= '0;
            sampCnt <= '0;
            chIdx   <= maskIdx;
          end
        end
        ST_SAMPLE: begin
          divCnt <= divCnt + 1'b1;
          if (ctrlWr) enable <= wrEn;
          if (tick) begin
            if (lastSample) begin
              state   <= ST_CONVERT;
              stepCnt <= '0;
            end else begin
              sampCnt <= sampCnt + 1'b1;
            end
          end
        end
        ST_CONVERT: begin
          divCnt <= divCnt + 1'b1;
          if (ctrlWr) enable <= wrEn;
          if (tick) begin
            if (lastStep) begin
              if (enNext && repeatMode) begin
                state   <= ST_SAMPLE;
                sampCnt <= '0;
              end else begin
                state  <= ST_IDLE;
                enable <= 1'b0;
              end
            end else begin
              stepCnt <= stepCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int PER_W  = 16,
  parameter logic [PER_W-1:0] PER_RESET = 16'h0578,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              cmpIn,
  input  seqStrobe_t        strobe,
  input  logic              enable,
  input  logic              busy,
  input  logic [CH_W-1:0]   chIdx,
  output logic              ctrlWr,
  output logic              active,
  output logic [NUM_CH-1:0] chMask,
  output logic              repeatMode,
  output logic [PER_W-1:0]  period,
  output logic [NUM_CH-1:0] chFlags,
  output logic              errFlag,
  output logic [RES_W-1:0]  dacCode,
  output logic              irq
);
  logic              pwrOn, rstRel, levelIrq, errIntEn, pulseReg;
  logic [31:0]       modeReg;
  logic [NUM_CH-1:0] chIntEn, setCh;
  logic [RES_W-1:0]  approx, trial, stepVal;
  logic [RES_W-1:0]  result [NUM_CH];
  logic [7:0]        resOff;

  assign ctrlWr     = busWe && (busAddr == ADDR_CTRL);
  assign active     = pwrOn & rstRel;
  assign repeatMode = modeReg[1];
  assign stepVal    = approx | (cmpIn ? trial : '0);
  assign dacCode    = approx | trial;
  assign setCh      = strobe.convDone ? (NUM_CH'(1) << chIdx) : '0;
  assign resOff     = busAddr - ADDR_RES0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOn    <= 1'b0;
      rstRel   <= 1'b0;
      modeReg  <= '0;
      chMask   <= '0;
      period   <= PER_RESET;
      chIntEn  <= '0;
      errIntEn <= 1'b0;
      levelIrq <= 1'b0;
      chFlags  <= '0;
      errFlag  <= 1'b0;
      pulseReg <= 1'b0;
      approx   <= '0;
      trial    <= '0;
    end else begin
      if (busWe) begin
        case (busAddr)
          ADDR_CTRL:   begin pwrOn <= busWdata[2]; rstRel <= busWdata[15]; end
          ADDR_MODE:   modeReg <= busWdata & MODE_MASK;
          ADDR_CHSEL:  chMask <= busWdata[NUM_CH-1:0];
          ADDR_TIMING: period <= busWdata[PER_W-1:0];
          ADDR_INTEN:  begin
            chIntEn  <= busWdata[NUM_CH-1:0];
            errIntEn <= busWdata[16];
            levelIrq <= busWdata[31];
          end
          default: ;
        endcase
      end
      chFlags  <= (chFlags & ~((busWe && busAddr == ADDR_STATUS) ? busWdata[NUM_CH-1:0] : '0)) | setCh;
      errFlag  <= (errFlag & ~(busWe && busAddr == ADDR_STATUS && busWdata[16])) | strobe.selErr;
      pulseReg <= (|(setCh & chIntEn)) | (strobe.selErr & errIntEn);
      if (strobe.sarInit) begin
        approx <= '0;
        trial  <= RES_W'(1) << (RES_W - 1);
      end else if (strobe.sarStep) begin
        approx <= stepVal;
        trial  <= trial >> 1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) result[g] <= '0;
      else if (strobe.convDone && chIdx == CH_W'(g)) result[g] <= stepVal;
    end
  end

  assign irq = levelIrq ? ((|(chFlags & chIntEn)) | (errFlag & errIntEn)) : pulseReg;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL:   busRdata = {16'd0, rstRel, 12'd0, pwrOn, busy, enable};
      ADDR_MODE:   busRdata = modeReg;
      ADDR_CHSEL:  busRdata[NUM_CH-1:0] = chMask;
      ADDR_TIMING: busRdata = {8'd0, CMP_FIXED, {(16-PER_W){1'b0}}, period};
      ADDR_INTEN:  begin
        busRdata[NUM_CH-1:0] = chIntEn;
        busRdata[16] = errIntEn;
        busRdata[31] = levelIrq;
      end
      ADDR_STATUS: begin
        busRdata[NUM_CH-1:0] = chFlags;
        busRdata[16] = errFlag;
      end
      ADDR_DIV:    busRdata = 32'd4;
      default: begin
        if (busAddr >= ADDR_RES0 && resOff < 8'(4 * NUM_CH) && resOff[1:0] == 2'b00)
          busRdata[RES_W-1:0] = result[resOff[CH_W+1:2]];
      end
    endcase
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int PER_W  = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busAddr,
  input  logic             busWe,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic             cmpIn,
  output logic [RES_W-1:0] dacCode,
  output logic [CH_W-1:0]  muxSel,
  output logic             irq
);
  seqStrobe_t        strobe;
  logic              enable, busy, ctrlWr, active, repeatMode, errFlag;
  logic [CH_W-1:0]   chIdx;
  logic [NUM_CH-1:0] chMask, chFlags;
  logic [PER_W-1:0]  period;

  assign muxSel = chIdx;

  sar_control #(.NUM_CH(NUM_CH), .RES_W(RES_W), .PER_W(PER_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrEn(busWdata[0]),
    .wrPwr(busWdata[2]), .wrRel(busWdata[15]), .active(active),
    .chMask(chMask), .repeatMode(repeatMode), .period(period),
    .strobe(strobe), .enable(enable), .busy(busy), .chIdx(chIdx)
  );

  sar_datapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .PER_W(PER_W)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cmpIn(cmpIn),
    .strobe(strobe), .enable(enable), .busy(busy), .chIdx(chIdx),
    .ctrlWr(ctrlWr), .active(active), .chMask(chMask),
    .repeatMode(repeatMode), .period(period), .chFlags(chFlags),
    .errFlag(errFlag), .dacCode(dacCode), .irq(irq)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              active,
  input logic              busy,
  input logic              enable,
  input logic [NUM_CH-1:0] chFlags,
  input logic              errFlag,
  input logic [CH_W-1:0]   muxSel
);
  // R11
  off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !busy);

  // R2
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(muxSel));

  // R4
  flag_from_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(chFlags & ~$past(chFlags))) |-> $past(busy));

  // R5
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !enable);

  // R8
  sel_err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy && !enable);
endmodule

bind sar_seq sar_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .active(active), .busy(busy), .enable(enable),
  .chFlags(chFlags), .errFlag(errFlag), .muxSel(muxSel)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  busAddr = 0;
  logic        busWe = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic        cmpIn;
  logic [11:0] dacCode;
  logic [2:0]  muxSel;
  logic        irq;
  logic [11:0] vin [8];
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  sar_seq uut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cmpIn(cmpIn),
    .dacCode(dacCode), .muxSel(muxSel), .irq(irq));

  assign cmpIn = (vin[muxSel] >= dacCode);

  // behavioural reference model
  bit mPwr, mRel, mEn, mBusy, mRpt, mLevel, mErrEn, mErr, mPulse;
  int mRem, mCh, mPeriod;
  bit [7:0] mChEn, mFlags, mMask;
  bit [11:0] mRes [8];

  function automatic int reloadCnt();
    return 4 * ((mPeriod == 0) ? 1 : mPeriod) + 48;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPwr = 0; mRel = 0; mEn = 0; mBusy = 0; mRpt = 0; mLevel = 0;
      mErrEn = 0; mErr = 0; mPulse = 0; mRem = 0; mCh = 0; mPeriod = 16'h578;
      mChEn = 0; mFlags = 0; mMask = 0;
      for (int i = 0; i < 8; i++) mRes[i] = 0;
    end else begin
      mPulse = 0;
      if (mBusy) begin
        mRem--;
        if (mRem == 0) begin
          mRes[mCh] = vin[mCh];
          mFlags[mCh] = 1;
          if (mChEn[mCh]) mPulse = 1;
          if (mEn && mRpt) mRem = reloadCnt();
          else begin mBusy = 0; mEn = 0; end
        end
      end
      if (busWe) begin
        case (busAddr)
          8'h00: begin
            mPwr = busWdata[2]; mRel = busWdata[15];
            if (!(mPwr && mRel)) begin mEn = 0; mBusy = 0; end
            else if (mBusy) mEn = busWdata[0];
            else if (busWdata[0]) begin
              if ($countones(mMask) == 1) begin
                mEn = 1; mBusy = 1; mRem = reloadCnt();
                for (int i = 0; i < 8; i++) if (mMask[i]) mCh = i;
              end else begin
                mErr = 1;
                if (mErrEn) mPulse = 1;
              end
            end
          end
          8'h04: mRpt = busWdata[1];
          8'h08: mMask = busWdata[7:0];
          8'h0C: mPeriod = busWdata[15:0];
          8'h20: begin mChEn = busWdata[7:0]; mErrEn = busWdata[16]; mLevel = busWdata[31]; end
          8'h24: begin mFlags &= ~busWdata[7:0]; if (busWdata[16]) mErr = 0; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    #3;
    if (rstN) begin
      bit expIrq;
      expIrq = mLevel ? ((|(mFlags & mChEn)) | (mErr & mErrEn)) : mPulse;
      check(irq == expIrq, "R10 irq per clock", irq, expIrq);
      if (busAddr == 8'h00 && !busWe)
        check(busRdata[1:0] == {mBusy, mEn}, "R3/R5 busy,enable per clock",
              busRdata[1:0], {mBusy, mEn});
      if (mBusy) check(muxSel == 3'(mCh), "R2 mux per clock", muxSel, mCh);
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0; busAddr = 0; busWdata = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
    busAddr = 0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int pulses;
    for (int i = 0; i < 8; i++) vin[i] = 12'(i * 300 + 7);
    vin[0] = 12'h000; vin[3] = 12'hA5C; vin[7] = 12'hFFF;
    waitCycles(3);
    rstN = 1;
    waitCycles(2);

    // reset state
    busRead(8'h00, r); check(r == 0, "R1 ctrl reset", r, 0);
    busRead(8'h0C, r); check(r == 32'h000E0578, "R1 timing reset", r, 32'h000E0578);
    busRead(8'h28, r); check(r == 4, "R1 divider", r, 4);
    busWrite(8'h28, 32'h7);
    busRead(8'h28, r); check(r == 4, "R1 divider ignores write", r, 4);
    busWrite(8'h0C, 32'hFFFF_0002);
    busRead(8'h0C, r); check(r == 32'h000E0002, "R1 timing write", r, 32'h000E0002);

    // gating by power and reset release
    busWrite(8'h08, 32'h08);
    busWrite(8'h00, 32'h0001);
    busRead(8'h00, r); check(r[1:0] == 0, "R11 no power", r, 0);
    busWrite(8'h00, 32'h0005);
    busRead(8'h00, r); check(r[1:0] == 0, "R11 reset held", r, 0);
    busRead(8'h24, r); check(r == 0, "R11 no flag", r, 0);

    // single conversion, pulse interrupt
    busWrite(8'h00, 32'h8004);
    busWrite(8'h20, 32'h0000_0008);
    busWrite(8'h00, 32'h8005);
    busRead(8'h00, r); check(r[1] == 1, "R2 busy after start", r[1], 1);
    check(muxSel == 3, "R2 mux select", muxSel, 3);
    pulses = 0;
    repeat (60) begin @(negedge clk); #2; if (irq) pulses++; end
    check(pulses == 1, "R10 single pulse", pulses, 1);
    busRead(8'h3C, r); check(r == 32'hA5C, "R3 result ch3", r, 32'hA5C);
    busRead(8'h24, r); check(r == 32'h8, "R4 status ch3", r, 32'h8);
    busRead(8'h00, r); check(r[1:0] == 0, "R5 single stops", r[1:0], 0);

    // write-1-clear
    busWrite(8'h24, 32'h0001_0004);
    busRead(8'h24, r); check(r == 32'h8, "R9 other bits kept", r, 32'h8);
    busWrite(8'h24, 32'h8);
    busRead(8'h24, r); check(r == 0, "R9 cleared", r, 0);

    // code extremes
    busWrite(8'h08, 32'h80);
    busWrite(8'h00, 32'h8005);
    waitCycles(60);
    busRead(8'h4C, r); check(r == 32'hFFF, "R3 full scale ch7", r, 32'hFFF);
    busWrite(8'h08, 32'h01);
    busWrite(8'h00, 32'h8005);
    waitCycles(60);
    busRead(8'h30, r); check(r == 0, "R3 zero ch0", r, 0);
    busRead(8'h24, r); check(r == 32'h81, "R4 flags ch0 ch7", r, 32'h81);

    // selection errors
    busWrite(8'h08, 32'h00);
    busWrite(8'h00, 32'h8005);
    busRead(8'h00, r); check(r[1:0] == 0, "R8 empty mask no start", r[1:0], 0);
    busRead(8'h24, r); check(r[16] == 1, "R8 error flag", r[16], 1);
    busWrite(8'h24, 32'h0001_0000);
    busWrite(8'h08, 32'h81);
    busWrite(8'h00, 32'h8005);
    busRead(8'h00, r); check(r[1:0] == 0, "R8 two bits no start", r[1:0], 0);
    busRead(8'h24, r); check(r[16] == 1, "R8 error flag again", r[16], 1);

    // level interrupt
    busWrite(8'h20, 32'h8001_0001);
    waitCycles(1); #2;
    check(irq == 1, "R10 level high", irq, 1);
    busWrite(8'h24, 32'h0001_0000);
    waitCycles(1); #2;
    check(irq == 1, "R10 level from ch0 flag", irq, 1);
    busWrite(8'h24, 32'h0000_00FF);
    waitCycles(1); #2;
    check(irq == 0, "R10 level cleared", irq, 0);

    // repeat mode, then stop during a conversion
    busWrite(8'h20, 32'h0000_0020);
    busWrite(8'h0C, 32'd20);
    busWrite(8'h04, 32'h2);
    busWrite(8'h08, 32'h20);
    vin[5] = 12'h123;
    busWrite(8'h00, 32'h8005);
    waitCycles(138);
    busRead(8'h44, r); check(r == 32'h123, "R6 first repeat result", r, 32'h123);
    vin[5] = 12'h456;
    waitCycles(128);
    busRead(8'h44, r); check(r == 32'h456, "R6 second repeat result", r, 32'h456);
    busRead(8'h00, r); check(r[1:0] == 2'b11, "R6 still running", r[1:0], 2'b11);
    busWrite(8'h00, 32'h8004);
    busRead(8'h00, r); check(r[1:0] == 2'b10, "R7 enable low busy high", r[1:0], 2'b10);
    vin[5] = 12'h789;
    waitCycles(140);
    busRead(8'h00, r); check(r[1:0] == 0, "R7 idle after finish", r[1:0], 0);
    busRead(8'h44, r); check(r == 32'h789, "R7 last result stored", r, 32'h789);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule